// File: doc/BRIEF.md
# Stream Link FIFO Channel

This block joins one producing master to one consuming slave through a first-in first-out store. Every entry holds a data word and, when enabled at build time, one sideband control bit that travels with that word. The master pushes with a write strobe and is held back by a full flag. The slave sees the head word, its control bit and an exists flag, and pops it with a read strobe.

Four build parameters shape the channel: the depth, the storage style (distributed, read without a clock, or block, read through a clocked output register), single-clock or dual-clock operation, and whether the control bit is stored. Depths the chosen style and clocking mode do not allow stop elaboration. In dual-clock mode each pointer crosses to the other side as Gray code through two flip-flops. Block storage adds one fall-through cycle before a word written into an empty channel is shown.

The slave side is run by a three-state machine. `RD_IDLE` shows nothing. It moves to `RD_SHOW` when the slave-side view of the write pointer differs from the read pointer (distributed style), or to `RD_PRIME` first (block style), where the output register is loaded. `RD_PRIME` always moves to `RD_SHOW` on the next edge. `RD_SHOW` raises exists. It stays there while a word remains after any pop on this edge, and returns to `RD_IDLE` when none does.

Top module: `stream_link_fifo`

## Requirements
- R1: In single-clock mode (`DUAL_CLK`=0) any depth from 1 to 8192 is accepted. Any other depth makes elaboration fail.
- R2: In dual-clock mode the depth must be a power of two: 16 to 128 with distributed storage, 512 to 8192 with block storage. Any other depth makes elaboration fail.
- R3: With `CARRY_CTRL`=1, `s_ctrl` equals the `m_ctrl` value written together with the word now on `s_data`.
- R4: With `CARRY_CTRL`=0, `s_ctrl` is always 0, whatever `m_ctrl` was written, and the store is `DATA_W` bits wide.
- R5: Words reach the slave in write order. A pop is taken on a `s_clk` edge where `s_rd` and `s_exists` are both high. While `s_exists` is high and no pop is taken, the head word and its control bit stay unchanged.
- R6: Distributed storage, single clock: a word written on edge k into an empty channel raises `s_exists` after edge k+1.
- R7: Block storage, single clock: the same write raises `s_exists` after edge k+2, one cycle later than R6.
- R8: `m_full` is high exactly while the write side counts `DEPTH` words held. A write while `m_full` is high is dropped and never reaches the slave.
- R9: A read while `s_exists` is low is ignored. The read pointer does not move, so the next written words still come out in order.
- R10: While `rst_n` is low the channel is empty, `s_exists` is low and `m_full` is low.
- R11: In dual-clock mode the master side uses `m_clk`, the slave side uses `s_clk`, and the pointers cross as Gray code through two flip-flops, so words survive unrelated clocks intact and in order. In single-clock mode `m_clk` and `s_clk` must carry the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_clk | input | 1 | Master-side clock |
| s_clk | input | 1 | Slave-side clock (same clock as m_clk in single-clock mode) |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| m_wr | input | 1 | Master write strobe |
| m_data | input | DATA_W | Master data word |
| m_ctrl | input | 1 | Master sideband control bit |
| m_full | output | 1 | Channel full; writes are dropped while high |
| s_rd | input | 1 | Slave read (pop) strobe |
| s_data | output | DATA_W | Head data word |
| s_ctrl | output | 1 | Control bit of the head word |
| s_exists | output | 1 | A head word is available |

## Verification
A single write into an empty channel, followed cycle by cycle, separates the distributed fall-through from the block fall-through. A fill past capacity, with one extra write, shows whether `m_full` rises at exactly `DEPTH` words and whether the dropped word stays out. Reads into an empty channel, followed by writes, show whether a stray read moves the read pointer. Mixed write/read streams at write-heavy, balanced and read-heavy duty cycles test ordering and the full flag while pops and writes share edges. Alternating control bits make a lost or swapped control bit visible. A 16-deep dual-clock run on unrelated clocks tests the Gray crossing, and the legality rule is probed at each depth boundary.

// File: rtl/stream_link_pkg.sv
package stream_link_pkg;

    // Slave-side presentation states
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_PRIME = 2'd1,
        RD_SHOW  = 2'd2
    } rd_state_e;

    // Legal depth for a given clocking mode and storage style
    function automatic bit depth_ok(input int depth, input bit dual, input bit block);
        if (!dual)
            return (depth >= 1) && (depth <= 8192);
        if ((depth < 1) || ((depth & (depth - 1)) != 0))
            return 1'b0;
        if (block)
            return (depth >= 512) && (depth <= 8192);
        return (depth >= 16) && (depth <= 128);
    endfunction

endpackage

// File: rtl/stream_link_store.sv
module stream_link_store #(
    parameter int DEPTH = 16,
    parameter int W     = 33,
    parameter int AW    = 4,
    parameter bit BLOCK = 1'b0
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic          rclk,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    generate
        if (BLOCK) begin : g_block
            logic [W-1:0] q_r;
            always_ff @(posedge rclk) begin
                q_r <= mem[raddr];
            end
            assign rdata = q_r;
        end else begin : g_dist
            assign rdata = mem[raddr];
        end
    endgenerate

endmodule

// File: rtl/stream_link_xing.sv
module stream_link_xing #(
    parameter int PW = 5
) (
    input  logic          src_clk,
    input  logic          dst_clk,
    input  logic          rst_n,
    input  logic [PW-1:0] src_bin,
    output logic [PW-1:0] dst_bin
);

    logic [PW-1:0] gray_q;
    logic [PW-1:0] sync1_q;
    logic [PW-1:0] sync2_q;

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) gray_q <= '0;
        else        gray_q <= src_bin ^ (src_bin >> 1);
    end

    always_ff @(posedge dst_clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
        end else begin
            sync1_q <= gray_q;
            sync2_q <= sync1_q;
        end
    end

    always_comb begin
        dst_bin[PW-1] = sync2_q[PW-1];
        for (int i = PW - 2; i >= 0; i--)
            dst_bin[i] = dst_bin[i+1] ^ sync2_q[i];
    end

    // R11: the crossing word changes by at most one bit per source edge
    assert_gray_step_R11: assert property (@(posedge src_clk) disable iff (!rst_n)
        $countones(gray_q ^ $past(gray_q)) <= 1);

endmodule

// File: rtl/stream_link_rdctl.sv
module stream_link_rdctl
    import stream_link_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int PW    = 5,
    parameter bit BLOCK = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] wr_seen,
    input  logic          rd_en,
    output logic          exists,
    output logic [PW-1:0] rd_ptr,
    output logic [AW-1:0] fetch_idx
);

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        if (p[AW-1:0] == AW'(DEPTH - 1))
            return {~p[PW-1], {AW{1'b0}}};
        return {p[PW-1], p[AW-1:0] + AW'(1)};
    endfunction

    rd_state_e     st_q, st_d;
    logic [PW-1:0] rd_q, rd_nxt;
    logic          pop, more;

    assign pop    = rd_en && (st_q == RD_SHOW);
    assign rd_nxt = pop ? bump(rd_q) : rd_q;
    assign more   = (wr_seen != rd_nxt);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RD_IDLE:  if (more) st_d = BLOCK ? RD_PRIME : RD_SHOW;
            RD_PRIME: st_d = RD_SHOW;
            RD_SHOW:  if (!more) st_d = RD_IDLE;
            default:  st_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RD_IDLE;
            rd_q <= '0;
        end else begin
            st_q <= st_d;
            rd_q <= rd_nxt;
        end
    end

    always_comb begin
        exists    = (st_q == RD_SHOW);
        rd_ptr    = rd_q;
        fetch_idx = rd_nxt[AW-1:0];
    end

    // R9: a read with nothing shown leaves the read pointer alone
    assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !exists) |=> (rd_q == $past(rd_q)));

    generate
        if (BLOCK) begin : g_blk_chk
            // R7: block storage takes one priming cycle before showing
            assert_fallthrough_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q == RD_IDLE && wr_seen != rd_q) |=> (st_q == RD_PRIME && !exists));
            assert_prime_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q == RD_PRIME) |=> exists);
        end else begin : g_dist_chk
            // R6: distributed storage shows on the next edge
            assert_fallthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q == RD_IDLE && wr_seen != rd_q) |=> exists);
        end
    endgenerate

endmodule

// File: rtl/stream_link_fifo.sv
module stream_link_fifo #(
    parameter int DEPTH      = 16,
    parameter bit DUAL_CLK   = 1'b0,
    parameter bit BLOCK_RAM  = 1'b0,
    parameter bit CARRY_CTRL = 1'b1,
    parameter int DATA_W     = 32
) (
    input  logic              m_clk,
    input  logic              s_clk,
    input  logic              rst_n,
    input  logic              m_wr,
    input  logic [DATA_W-1:0] m_data,
    input  logic              m_ctrl,
    output logic              m_full,
    input  logic              s_rd,
    output logic [DATA_W-1:0] s_data,
    output logic              s_ctrl,
    output logic              s_exists
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int PW = AW + 1;
    localparam int W  = CARRY_CTRL ? DATA_W + 1 : DATA_W;

    // R1, R2: depth legality for the chosen mode and style
    generate
        if (!stream_link_pkg::depth_ok(DEPTH, DUAL_CLK, BLOCK_RAM)) begin : g_bad_depth
            $error("stream_link_fifo: DEPTH not allowed for this clocking mode and storage style");
        end
    endgenerate

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        if (p[AW-1:0] == AW'(DEPTH - 1))
            return {~p[PW-1], {AW{1'b0}}};
        return {p[PW-1], p[AW-1:0] + AW'(1)};
    endfunction

    logic [PW-1:0] wr_q, rd_ptr, wr_seen, rd_seen;
    logic [AW-1:0] fetch_idx, raddr;
    logic [W-1:0]  wdata, rdata;
    logic          accept;

    // Master side
    assign m_full = (wr_q[AW-1:0] == rd_seen[AW-1:0]) && (wr_q[PW-1] != rd_seen[PW-1]);
    assign accept = m_wr && !m_full;

    always_ff @(posedge m_clk or negedge rst_n) begin
        if (!rst_n)      wr_q <= '0;
        else if (accept) wr_q <= bump(wr_q);
    end

    // Control bit packing
    generate
        if (CARRY_CTRL) begin : g_ctrl
            assign wdata  = {m_ctrl, m_data};
            assign s_ctrl = rdata[W-1];
        end else begin : g_noctrl
            assign wdata  = m_data;
            assign s_ctrl = 1'b0;
        end
    endgenerate
    assign s_data = rdata[DATA_W-1:0];

    // Pointer crossing
    generate
        if (DUAL_CLK) begin : g_dual
            stream_link_xing #(.PW(PW)) wr_xing_i (
                .src_clk(m_clk), .dst_clk(s_clk), .rst_n(rst_n),
                .src_bin(wr_q), .dst_bin(wr_seen));
            stream_link_xing #(.PW(PW)) rd_xing_i (
                .src_clk(s_clk), .dst_clk(m_clk), .rst_n(rst_n),
                .src_bin(rd_ptr), .dst_bin(rd_seen));
        end else begin : g_single
            assign wr_seen = wr_q;
            assign rd_seen = rd_ptr;
        end
    endgenerate

    stream_link_rdctl #(.DEPTH(DEPTH), .AW(AW), .PW(PW), .BLOCK(BLOCK_RAM)) rdctl_i (
        .clk(s_clk), .rst_n(rst_n), .wr_seen(wr_seen), .rd_en(s_rd),
        .exists(s_exists), .rd_ptr(rd_ptr), .fetch_idx(fetch_idx));

    assign raddr = BLOCK_RAM ? fetch_idx : rd_ptr[AW-1:0];

    stream_link_store #(.DEPTH(DEPTH), .W(W), .AW(AW), .BLOCK(BLOCK_RAM)) store_i (
        .wclk(m_clk), .we(accept), .waddr(wr_q[AW-1:0]), .wdata(wdata),
        .rclk(s_clk), .raddr(raddr), .rdata(rdata));

    // R8: a write while full does not move the write pointer
    assert_no_overflow_R8: assert property (@(posedge m_clk) disable iff (!rst_n)
        (m_wr && m_full) |=> (wr_q == $past(wr_q)));

    // R5: the head word holds until it is popped
    assert_head_held_R5: assert property (@(posedge s_clk) disable iff (!rst_n)
        (s_exists && !s_rd) |=> (s_exists && $stable(s_data) && $stable(s_ctrl)));

endmodule

// File: tb/stream_link_fifo_tb.sv
module stream_link_fifo_tb_top;

    logic clk = 1'b0;
    logic sclk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;
    always #7 sclk = ~sclk;

    logic        wr[3], rd[3], ctl_in[3], full[3], ex[3], ctl_o[3];
    logic [31:0] din[3], dout[3];
    logic [32:0] q[3][$];

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // k=0: single clock, distributed, depth 5, control carried
    stream_link_fifo #(.DEPTH(5), .DUAL_CLK(1'b0), .BLOCK_RAM(1'b0), .CARRY_CTRL(1'b1)) dut_i (
        .m_clk(clk), .s_clk(clk), .rst_n(rst_n), .m_wr(wr[0]), .m_data(din[0]), .m_ctrl(ctl_in[0]),
        .m_full(full[0]), .s_rd(rd[0]), .s_data(dout[0]), .s_ctrl(ctl_o[0]), .s_exists(ex[0]));
    // k=1: single clock, block, depth 4, control dropped
    stream_link_fifo #(.DEPTH(4), .DUAL_CLK(1'b0), .BLOCK_RAM(1'b1), .CARRY_CTRL(1'b0)) blk_i (
        .m_clk(clk), .s_clk(clk), .rst_n(rst_n), .m_wr(wr[1]), .m_data(din[1]), .m_ctrl(ctl_in[1]),
        .m_full(full[1]), .s_rd(rd[1]), .s_data(dout[1]), .s_ctrl(ctl_o[1]), .s_exists(ex[1]));
    // k=2: dual clock, distributed, depth 16, control carried
    stream_link_fifo #(.DEPTH(16), .DUAL_CLK(1'b1), .BLOCK_RAM(1'b0), .CARRY_CTRL(1'b1)) dcl_i (
        .m_clk(clk), .s_clk(sclk), .rst_n(rst_n), .m_wr(wr[2]), .m_data(din[2]), .m_ctrl(ctl_in[2]),
        .m_full(full[2]), .s_rd(rd[2]), .s_data(dout[2]), .s_ctrl(ctl_o[2]), .s_exists(ex[2]));

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] val(input int k, input int i);
        return 32'h3C00_0000 ^ (32'(k) << 24) ^ (32'(i) * 32'h0001_0203);
    endfunction

    function automatic int depth_of(input int k);
        return (k == 0) ? 5 : (k == 1) ? 4 : 16;
    endfunction

    task automatic wait_s(input int k);
        if (k == 2) @(negedge sclk);
        else        @(negedge clk);
    endtask

    // Queue an accepted word; control is 0 when not carried (R4)
    task automatic expect_word(input int k, input logic c, input logic [31:0] d);
        q[k].push_back({(k == 1) ? 1'b0 : c, d});
    endtask

    task automatic drain(input int k, input string req);
        int guard;
        logic [32:0] e;
        guard = 0;
        while (!ex[k] && guard < 12) begin
            wait_s(k);
            guard++;
        end
        while (q[k].size() > 0) begin
            e = q[k].pop_front();
            chk(ex[k] === 1'b1, req, 64'(ex[k]), 64'd1);
            chk({ctl_o[k], dout[k]} == e, req, 64'({ctl_o[k], dout[k]}), 64'(e));
            rd[k] = 1'b1;
            wait_s(k);
            rd[k] = 1'b0;
        end
    endtask

    task automatic latency_test(input int k);
        string req;
        req = (k == 0) ? "R6" : "R7";
        @(negedge clk);
        wr[k] = 1'b1; din[k] = val(k, 99); ctl_in[k] = 1'b1;
        expect_word(k, 1'b1, val(k, 99));
        @(negedge clk);
        wr[k] = 1'b0;
        chk(ex[k] == 1'b0, req, 64'(ex[k]), 64'd0);
        @(negedge clk);
        chk(ex[k] == (k == 0), req, 64'(ex[k]), 64'(k == 0));
        @(negedge clk);
        chk(ex[k] == 1'b1, req, 64'(ex[k]), 64'd1);
        drain(k, "R5");
    endtask

    task automatic fill_test(input int k);
        int d;
        d = depth_of(k);
        for (int i = 0; i <= d; i++) begin
            @(negedge clk);
            chk(full[k] == (i == d), "R8", 64'(full[k]), 64'(i == d));
            wr[k] = 1'b1; din[k] = val(k, i); ctl_in[k] = ~i[0];
            if (i < d) expect_word(k, ~i[0], val(k, i));
        end
        @(negedge clk);
        wr[k] = 1'b0;
        chk(full[k] == 1'b1, "R8", 64'(full[k]), 64'd1);
        drain(k, (k == 0) ? "R3" : "R4");
        repeat (3) @(negedge clk);
        chk(ex[k] == 1'b0, "R8", 64'(ex[k]), 64'd0);
        chk(full[k] == 1'b0, "R8", 64'(full[k]), 64'd0);
    endtask

    task automatic underflow_test(input int k);
        @(negedge clk);
        rd[k] = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(ex[k] == 1'b0, "R9", 64'(ex[k]), 64'd0);
        end
        rd[k] = 1'b0;
        for (int i = 0; i < 2; i++) begin
            wr[k] = 1'b1; din[k] = val(k, 40 + i); ctl_in[k] = i[0];
            expect_word(k, i[0], val(k, 40 + i));
            @(negedge clk);
        end
        wr[k] = 1'b0;
        drain(k, "R9");
    endtask

    task automatic stream_test(input int k);
        int d, cnt, n;
        bit w, r;
        d = depth_of(k);
        cnt = 0;
        n = 0;
        for (int ph = 0; ph < 3; ph++) begin
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                chk(full[k] == (cnt == d), "R8", 64'(full[k]), 64'(cnt == d));
                if (ex[k]) begin
                    if (q[k].size() == 0) chk(1'b0, "R5", 64'd1, 64'd0);
                    else chk({ctl_o[k], dout[k]} == q[k][0], "R5",
                             64'({ctl_o[k], dout[k]}), 64'(q[k][0]));
                end
                w = ((i * 13 + ph * 3) % 11) < ((ph == 0) ? 8 : (ph == 1) ? 5 : 2);
                r = ((i * 7 + ph) % 9) < ((ph == 0) ? 3 : (ph == 1) ? 5 : 8);
                if (r && ex[k]) begin
                    void'(q[k].pop_front());
                    cnt--;
                end
                if (w && !full[k]) begin
                    expect_word(k, n[1], val(k, 100 + n));
                    cnt++;
                end
                wr[k] = w; din[k] = val(k, 100 + n); ctl_in[k] = n[1];
                rd[k] = r;
                if (w && !full[k]) n++;
            end
        end
        @(negedge clk);
        wr[k] = 1'b0; rd[k] = 1'b0;
        if (ex[k] && q[k].size() > 0 && rd[k]) void'(q[k].pop_front());
        drain(k, "R5");
    endtask

    task automatic dual_test();
        for (int i = 0; i <= 16; i++) begin
            @(negedge clk);
            chk(full[2] == (i == 16), "R8", 64'(full[2]), 64'(i == 16));
            wr[2] = 1'b1; din[2] = val(2, i); ctl_in[2] = i[0];
            if (i < 16) expect_word(2, i[0], val(2, i));
        end
        @(negedge clk);
        wr[2] = 1'b0;
        drain(2, "R11");
        fork
            begin
                int n;
                n = 0;
                while (n < 40) begin
                    @(negedge clk);
                    if (wr[2] && !full[2]) n++;
                    wr[2] = 1'b0;
                    if (n < 40 && !full[2]) begin
                        wr[2] = 1'b1; din[2] = val(2, 200 + n); ctl_in[2] = n[0];
                        expect_word(2, n[0], val(2, 200 + n));
                    end
                end
                wr[2] = 1'b0;
            end
            begin
                int m;
                logic [32:0] e;
                m = 0;
                while (m < 40) begin
                    @(negedge sclk);
                    rd[2] = 1'b0;
                    if (ex[2] && q[2].size() > 0) begin
                        e = q[2].pop_front();
                        chk({ctl_o[2], dout[2]} == e, "R11", 64'({ctl_o[2], dout[2]}), 64'(e));
                        rd[2] = 1'b1;
                        m++;
                    end
                end
                @(negedge sclk);
                rd[2] = 1'b0;
            end
        join
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin
            wr[k] = 1'b0; rd[k] = 1'b0; ctl_in[k] = 1'b0; din[k] = '0;
        end
        repeat (3) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            chk(ex[k] == 1'b0, "R10", 64'(ex[k]), 64'd0);
            chk(full[k] == 1'b0, "R10", 64'(full[k]), 64'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R1: single-clock depth range
        chk(stream_link_pkg::depth_ok(1, 1'b0, 1'b0) == 1'b1, "R1", 64'd0, 64'd1);
        chk(stream_link_pkg::depth_ok(0, 1'b0, 1'b0) == 1'b0, "R1", 64'd1, 64'd0);
        chk(stream_link_pkg::depth_ok(8192, 1'b0, 1'b1) == 1'b1, "R1", 64'd0, 64'd1);
        chk(stream_link_pkg::depth_ok(8193, 1'b0, 1'b0) == 1'b0, "R1", 64'd1, 64'd0);
        // R2: dual-clock ranges by style
        chk(stream_link_pkg::depth_ok(15, 1'b1, 1'b0) == 1'b0, "R2", 64'd1, 64'd0);
        chk(stream_link_pkg::depth_ok(16, 1'b1, 1'b0) == 1'b1, "R2", 64'd0, 64'd1);
        chk(stream_link_pkg::depth_ok(128, 1'b1, 1'b0) == 1'b1, "R2", 64'd0, 64'd1);
        chk(stream_link_pkg::depth_ok(256, 1'b1, 1'b0) == 1'b0, "R2", 64'd1, 64'd0);
        chk(stream_link_pkg::depth_ok(48, 1'b1, 1'b0) == 1'b0, "R2", 64'd1, 64'd0);
        chk(stream_link_pkg::depth_ok(256, 1'b1, 1'b1) == 1'b0, "R2", 64'd1, 64'd0);
        chk(stream_link_pkg::depth_ok(512, 1'b1, 1'b1) == 1'b1, "R2", 64'd0, 64'd1);
        chk(stream_link_pkg::depth_ok(8192, 1'b1, 1'b1) == 1'b1, "R2", 64'd0, 64'd1);

        for (int k = 0; k < 2; k++) latency_test(k);
        for (int k = 0; k < 2; k++) fill_test(k);
        for (int k = 0; k < 2; k++) underflow_test(k);
        for (int k = 0; k < 2; k++) stream_test(k);
        dual_test();

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule